// File: doc/BRIEF.md
# Serial Equalizer Gain Control Register

This block is the control front end of a stereo seven-band graphic equalizer. A host drives three slow serial lines: a shift clock, a data line and an enable line. The block samples those lines with a much faster system clock. While enable is low, it collects a one-byte device address. When enable rises, it compares that byte with the address chosen by a strap input. While enable is high, it shifts in a frame of band gain codes for one channel.

When enable falls, a frame that matched the address and had exactly the right length is copied into holding registers. Each held 4-bit gain code is then decoded into a registered one-hot select. That select closes exactly one of the thirteen gain taps of the analog switch matrix for that band. Two devices can share one bus by strapping them to different addresses.

Top module: `eq_gain_ctrl`

## Requirements
- R1: After reset, every band of both channels selects the flat tap, which is bit 6 of its band field.
- R2: The 8 bits clocked in while enable is low are the address, sent LSB first; the last 8 such bits before enable rises count. With the strap high, the accepted address is 0x8C; with the strap low, it is 0x8D.
- R3: A frame whose address does not match the strap is ignored, and both channels keep their previous selects.
- R4: While enable is high, a frame carries 29 bits. Bit 0 selects the channel (0 = left, 1 = right). It is followed by the codes of band 0 through band 6, each 4 bits wide and sent LSB first.
- R5: A frame that delivers any bit count other than 29 while enable is high is discarded, and both channels keep their previous selects.
- R6: The outputs do not change while enable is high. An accepted frame appears on the outputs within 8 system clock cycles after enable falls at the pin.
- R7: Within a band field, code n from 0 to 12 sets bit n: bit 0 is -12 dB, bit 6 is flat and bit 12 is +12 dB, in 2 dB steps. Codes 13, 14 and 15 set bit 6.
- R8: A frame for one channel leaves the other channel's selects unchanged.
- R9: Every band field of both outputs has exactly one bit set at all times after reset.
- R10: Band b occupies output bits [13*b+12 : 13*b] of its channel's output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk_i | input | 1 | Serial shift clock; data is taken on its rising edge |
| ser_dat_i | input | 1 | Serial data |
| ser_en_i | input | 1 | Enable: low = address phase, high = data phase, falling edge = latch |
| addr_strap_i | input | 1 | Address strap: 1 selects 0x8C, 0 selects 0x8D |
| sel_left_o | output | 91 | Left channel one-hot tap selects, 13 per band |
| sel_right_o | output | 91 | Right channel one-hot tap selects, 13 per band |

## Verification
The bench targets the frame-acceptance corners:
- A frame one bit short or one bit long. A design that counts loosely would latch shifted garbage.
- The non-matching address under each strap value. A reversed strap mapping or a wrong address bit order would let a foreign frame through.

The outputs are also probed just before enable falls. A design that wrote through while shifting would already show the new gains there. Codes 13 to 15 and the extreme codes 0 and 12 are applied to catch a decoder that drops taps or selects nothing. Every update is checked on both channels, so a channel-select mix-up shows as a change on the wrong side.

// File: rtl/eqc_pkg.sv
package eqc_pkg;
  localparam int BANDS      = 7;
  localparam int CODE_W     = 4;
  localparam int STEPS      = 13;
  localparam int FLAT_CODE  = 6;
  localparam int ADDR_W     = 8;
  localparam int FRAME_BITS = 1 + BANDS * CODE_W;

  function automatic logic [STEPS-1:0] code_to_sel(input logic [CODE_W-1:0] code);
    logic [STEPS-1:0] s;
    s = '0;
    if (int'(code) >= STEPS) s[FLAT_CODE] = 1'b1;
    else                     s[code]      = 1'b1;
    return s;
  endfunction
endpackage

// File: rtl/eqc_sync.sv
module eqc_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      q_o    <= '0;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end
endmodule

// File: rtl/eqc_rx.sv
module eqc_rx #(
  parameter int          ADDR_W     = eqc_pkg::ADDR_W,
  parameter int          FRAME_BITS = eqc_pkg::FRAME_BITS,
  parameter logic [7:0]  ADDR_HI    = 8'h8C,
  parameter logic [7:0]  ADDR_LO    = 8'h8D
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  sclk_i,
  input  logic                  sdat_i,
  input  logic                  sen_i,
  input  logic                  strap_i,
  output logic                  load_o,
  output logic [FRAME_BITS-1:0] frame_o
);
  localparam int CNT_W = $clog2(FRAME_BITS + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0] CNT_SAT  = '1;

  logic                  sclk_d, sen_d;
  logic [ADDR_W-1:0]     addr_sr;
  logic [FRAME_BITS-1:0] data_sr;
  logic [CNT_W-1:0]      cnt;
  logic                  addr_ok;
  logic [ADDR_W-1:0]     own_addr;

  wire sclk_rise = sclk_i & ~sclk_d;
  wire sen_rise  = sen_i & ~sen_d;
  wire sen_fall  = ~sen_i & sen_d;

  assign own_addr = strap_i ? ADDR_HI[ADDR_W-1:0] : ADDR_LO[ADDR_W-1:0];
  assign frame_o  = data_sr;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d  <= 1'b0;
      sen_d   <= 1'b0;
      addr_sr <= '0;
      data_sr <= '0;
      cnt     <= '0;
      addr_ok <= 1'b0;
      load_o  <= 1'b0;
    end else begin
      sclk_d <= sclk_i;
      sen_d  <= sen_i;
      load_o <= 1'b0;
      if (sen_rise) begin
        addr_ok <= (addr_sr == own_addr);
        cnt     <= '0;
      end
      if (sclk_rise) begin
        if (!sen_i) begin
          addr_sr <= {sdat_i, addr_sr[ADDR_W-1:1]};
        end else begin
          data_sr <= {sdat_i, data_sr[FRAME_BITS-1:1]};
          if (cnt != CNT_SAT) cnt <= cnt + 1'b1;
        end
      end
      if (sen_fall) load_o <= addr_ok && (cnt == CNT_FULL);
    end
  end

  // R5
  load_len_chk: assert property (@(posedge clk) disable iff (rst)
    load_o |-> ($past(cnt) == CNT_FULL));

  // R3
  load_addr_chk: assert property (@(posedge clk) disable iff (rst)
    load_o |-> $past(addr_ok));
endmodule

// File: rtl/eqc_decode.sv
module eqc_decode #(
  parameter int BANDS     = eqc_pkg::BANDS,
  parameter int CODE_W    = eqc_pkg::CODE_W,
  parameter int STEPS     = eqc_pkg::STEPS,
  parameter int FLAT_CODE = eqc_pkg::FLAT_CODE
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [BANDS*CODE_W-1:0]   codes_i,
  output logic [BANDS*STEPS-1:0]    sel_o
);
  localparam logic [STEPS-1:0] FLAT_SEL = STEPS'(1) << FLAT_CODE;

  for (genvar b = 0; b < BANDS; b++) begin : g_band
    always_ff @(posedge clk) begin
      if (rst) sel_o[b*STEPS +: STEPS] <= FLAT_SEL;
      else     sel_o[b*STEPS +: STEPS] <= eqc_pkg::code_to_sel(codes_i[b*CODE_W +: CODE_W]);
    end

    // R9
    band_onehot_chk: assert property (@(posedge clk) disable iff (rst)
      $countones(sel_o[b*STEPS +: STEPS]) == 1);
  end
endmodule

// File: rtl/eq_gain_ctrl.sv
module eq_gain_ctrl #(
  parameter int BANDS  = eqc_pkg::BANDS,
  parameter int CODE_W = eqc_pkg::CODE_W,
  parameter int STEPS  = eqc_pkg::STEPS
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   ser_clk_i,
  input  logic                   ser_dat_i,
  input  logic                   ser_en_i,
  input  logic                   addr_strap_i,
  output logic [BANDS*STEPS-1:0] sel_left_o,
  output logic [BANDS*STEPS-1:0] sel_right_o
);
  localparam int FB     = 1 + BANDS * CODE_W;
  localparam int CH     = 2;
  localparam int CODE_V = BANDS * CODE_W;

  logic [3:0]        sync_q;
  logic              load;
  logic [FB-1:0]     frame;
  logic [CH-1:0][CODE_V-1:0] codes_q;
  logic [CH-1:0][BANDS*STEPS-1:0] sel_all;

  eqc_sync #(.W(4)) i_sync (
    .clk (clk),
    .rst (rst),
    .d_i ({addr_strap_i, ser_en_i, ser_dat_i, ser_clk_i}),
    .q_o (sync_q)
  );

  eqc_rx #(.FRAME_BITS(FB)) i_rx (
    .clk     (clk),
    .rst     (rst),
    .sclk_i  (sync_q[0]),
    .sdat_i  (sync_q[1]),
    .sen_i   (sync_q[2]),
    .strap_i (sync_q[3]),
    .load_o  (load),
    .frame_o (frame)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < CH; c++)
        for (int b = 0; b < BANDS; b++)
          codes_q[c][b*CODE_W +: CODE_W] <= CODE_W'(eqc_pkg::FLAT_CODE);
    end else if (load) begin
      codes_q[frame[0]] <= frame[FB-1:1];
    end
  end

  for (genvar c = 0; c < CH; c++) begin : g_ch
    eqc_decode #(.BANDS(BANDS), .CODE_W(CODE_W), .STEPS(STEPS)) i_dec (
      .clk     (clk),
      .rst     (rst),
      .codes_i (codes_q[c]),
      .sel_o   (sel_all[c])
    );
  end

  assign sel_left_o  = sel_all[0];
  assign sel_right_o = sel_all[1];

  // R6
  hold_until_load_chk: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(codes_q));
endmodule

// File: tb/test_eq_gain_ctrl.sv
module test_eq_gain_ctrl;
  localparam int NB = 7;
  localparam int NS = 13;
  localparam int VW = NB * NS;

  typedef struct {
    logic [VW-1:0] l;
    logic [VW-1:0] r;
    string         tag;
  } exp_t;

  logic clk = 0, rst = 1;
  logic sclk = 0, sdat = 0, sen = 0, strap = 1;
  logic [VW-1:0] sel_l, sel_r;

  int vectors = 0, miscompares = 0;
  exp_t sb[$];
  event frame_ev;
  logic [NB-1:0][3:0] m_l, m_r;

  always #5 clk = ~clk;

  eq_gain_ctrl i_eq_gain_ctrl (
    .clk(clk), .rst(rst), .ser_clk_i(sclk), .ser_dat_i(sdat),
    .ser_en_i(sen), .addr_strap_i(strap),
    .sel_left_o(sel_l), .sel_right_o(sel_r)
  );

  function automatic logic [VW-1:0] to_vec(input logic [NB-1:0][3:0] c);
    logic [VW-1:0] v = '0;
    for (int b = 0; b < NB; b++) begin
      int k = (int'(c[b]) > 12) ? 6 : int'(c[b]);
      v[b*NS + k] = 1'b1;
    end
    return v;
  endfunction

  function automatic bit all_onehot(input logic [VW-1:0] v);
    for (int b = 0; b < NB; b++)
      if ($countones(v[b*NS +: NS]) != 1) return 0;
    return 1;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [VW-1:0] act,
                     input logic [VW-1:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic pulse(input logic b);
    @(negedge clk) sdat = b;
    repeat (4) @(negedge clk);
    sclk = 1;
    repeat (4) @(negedge clk);
    sclk = 0;
  endtask

  task automatic send_frame(input logic [7:0] adr, input logic ch,
                            input logic [NB-1:0][3:0] c, input int nbits,
                            input string tag);
    logic [31:0] fr = '0;
    bit acc;
    fr[0] = ch;
    for (int b = 0; b < NB; b++) fr[4*b+1 +: 4] = c[b];
    sen = 0;
    for (int i = 0; i < 8; i++) pulse(adr[i]);
    repeat (4) @(negedge clk);
    sen = 1;
    repeat (4) @(negedge clk);
    for (int i = 0; i < nbits; i++) pulse(i < 29 ? fr[i] : 1'b1);
    repeat (6) @(negedge clk);
    // R6: nothing visible before enable falls
    chk(sel_l == to_vec(m_l), {"R6 left held ", tag}, sel_l, to_vec(m_l));
    chk(sel_r == to_vec(m_r), {"R6 right held ", tag}, sel_r, to_vec(m_r));
    sen = 0;
    acc = (adr == (strap ? 8'h8C : 8'h8D)) && (nbits == 29);
    if (acc) begin
      if (ch) m_r = c; else m_l = c;
    end
    sb.push_back('{l: to_vec(m_l), r: to_vec(m_r), tag: tag});
    ->frame_ev;
    repeat (30) @(negedge clk);
  endtask

  // monitor: pops expected items once the update window has passed
  initial begin
    forever begin
      exp_t e;
      @(frame_ev);
      repeat (8) @(negedge clk);
      e = sb.pop_front();
      chk(sel_l == e.l, {"left ", e.tag}, sel_l, e.l);
      chk(sel_r == e.r, {"right ", e.tag}, sel_r, e.r);
      chk(all_onehot(sel_l) && all_onehot(sel_r), {"R9 onehot ", e.tag}, sel_l, sel_r);
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [VW-1:0] flat;
    for (int b = 0; b < NB; b++) begin m_l[b] = 4'd6; m_r[b] = 4'd6; end
    flat = '0;
    for (int b = 0; b < NB; b++) flat[b*NS + 6] = 1'b1;
    repeat (4) @(negedge clk);
    rst = 0;
    repeat (4) @(negedge clk);
    // R1 / R10: flat tap is bit 13*b+6
    chk(sel_l == flat, "R1 reset left", sel_l, flat);
    chk(sel_r == flat, "R1 reset right", sel_r, flat);

    // R2 R4 R7 R8 R10: strap high accepts 0x8C, left channel
    send_frame(8'h8C, 1'b0, {4'd6, 4'd5, 4'd4, 4'd3, 4'd2, 4'd1, 4'd0}, 29, "R2 R4 R8 left write");
    // R4 R7: right channel, top codes
    send_frame(8'h8C, 1'b1, {4'd7, 4'd8, 4'd9, 4'd10, 4'd11, 4'd12, 4'd12}, 29, "R4 R7 right write");
    // R7: out-of-range codes give flat
    send_frame(8'h8C, 1'b0, {4'd15, 4'd14, 4'd13, 4'd12, 4'd0, 4'd13, 4'd15}, 29, "R7 codes 13-15");
    // R3: wrong address ignored
    send_frame(8'h8D, 1'b1, {NB{4'd0}}, 29, "R3 mismatch strap high");
    // R5: short and long frames discarded
    send_frame(8'h8C, 1'b1, {NB{4'd3}}, 28, "R5 short frame");
    send_frame(8'h8C, 1'b0, {NB{4'd9}}, 30, "R5 long frame");
    // R2 R3: strap low
    strap = 0;
    repeat (10) @(negedge clk);
    send_frame(8'h8C, 1'b1, {NB{4'd1}}, 29, "R3 mismatch strap low");
    send_frame(8'h8D, 1'b1, {4'd0, 4'd2, 4'd4, 4'd6, 4'd8, 4'd10, 4'd12}, 29, "R2 strap low accept");
    send_frame(8'h8D, 1'b0, {NB{4'd12}}, 29, "R8 left only");
    repeat (20) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule